// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block gives software access to the management registers of an Ethernet PHY over the two-wire MDC/MDIO interface defined in IEEE 802.3 clause 22. Software sees two 32-bit registers: a control register and a data register. To write a PHY register, software first loads the 16-bit value into the data register. It then writes the control register with the PHY address, the register number and the write flag set. To read a PHY register, software writes the control register with the write flag clear.

A control-register write starts a transaction and sets the busy bit. The controller produces the MDC clock from the system clock and shifts out a complete management frame. The frame is a 32-bit preamble of ones, start `01`, an opcode, the PHY address, the register number, a turnaround and sixteen data bits, most significant bit first. On a read the controller releases MDIO from the turnaround onward and samples the PHY's answer. At the end it places the result in the low half of the data register and clears busy. Software polls busy and issues no new transaction until busy is clear.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Control register layout: bits 15:11 hold the PHY address, bits 10:6 hold the register number, bit 1 is the write flag and bit 0 is busy. Bits 31:16 and 5:2 always read zero, whatever was written. The data register reads its 16-bit value in bits 15:0 with bits 31:16 zero. The select input is 0 for the control register and 1 for the data register.
- R2: A control-register write while idle starts a transaction, and busy reads 1 from the next clock on.
- R3: While idle, MDC is held low and MDIO is not driven. Busy returns to 0 once the last frame bit has completed.
- R4: A transaction with the write flag set sends, MSB first, 32 ones, `01`, opcode `01`, the 5-bit PHY address, the 5-bit register number, turnaround `10` and the 16-bit data register value, driving MDIO for all 64 bits.
- R5: A transaction with the write flag clear sends the preamble, `01`, opcode `10`, the PHY address and the register number. It then stops driving MDIO for the 2 turnaround bits and the 16 data bits.
- R6: After a read, the 16 bits sampled from MDIO on the rising MDC edges of the data field (first bit into bit 15) appear in data register bits 15:0 once busy clears. The turnaround bits are not captured.
- R7: A control-register write while busy is set is ignored: the fields and the frame in progress are unchanged.
- R8: One MDC period is 2×HALF_DIV system clocks and a transaction lasts exactly 128×HALF_DIV clocks. MDIO changes only on falling MDC edges, apart from the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects control register, 1 selects data register |
| csr_wdata | input | 32 | Register write data |
| ctl_rdata | output | 32 | Control register contents |
| dat_rdata | output | 32 | Data register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value from the pad |

## Verification
The bench acts as a PHY. It records every MDIO bit and enable state on rising MDC and, for reads, returns a value on falling MDC, with a `0` in the second turnaround slot.

Each corner case it targets exposes a specific fault:
- If the opcode or field order is swapped, the recorded header is wrong.
- If the turnaround is driven during a read, the enable pattern is wrong.
- If the sampling edge or data alignment is off, the read-back value is shifted.
- If a control write during busy is not ignored, the fields change or the frame is corrupted mid-flight.
- If the divider or bit count is off, the measured busy time differs from 128×HALF_DIV clocks.
- If reserved bits are not masked, an all-ones write reads back wrongly.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  localparam int POS_PHY  = 11;
  localparam int POS_REG  = 6;
  localparam int POS_WR   = 1;
  localparam int POS_BUSY = 0;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } csr_sel_e;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] SOF      = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(HALF_DIV) + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  always_comb begin
    tick      = run && (cnt_q == CW'(HALF_DIV - 1));
    rise_tick = tick && !mdc_q;
    fall_tick = tick && mdc_q;
    cnt_d     = cnt_q;
    mdc_d     = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_in,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IW        = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DAT_IDX   = PRE_LEN + 16;

  logic [FRAME_LEN-1:0] sreg_q, sreg_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic                 act_q, act_d;
  logic                 wr_q, wr_d;
  logic [DATA_W-1:0]    cap_q, cap_d;
  logic                 last_bit;

  always_comb begin
    sreg_d   = sreg_q;
    idx_d    = idx_q;
    act_d    = act_q;
    wr_d     = wr_q;
    cap_d    = cap_q;
    last_bit = (idx_q == IW'(FRAME_LEN - 1));
    done     = act_q && fall_tick && last_bit;
    if (start && !act_q) begin
      sreg_d = {{PRE_LEN{1'b1}}, SOF, (wr ? OP_WRITE : OP_READ), phy, regad,
                TA_DRIVE, (wr ? wdata : {DATA_W{1'b0}})};
      idx_d  = '0;
      act_d  = 1'b1;
      wr_d   = wr;
      cap_d  = '0;
    end else if (act_q) begin
      if (rise_tick && !wr_q && (idx_q >= IW'(DAT_IDX)))
        cap_d = {cap_q[DATA_W-2:0], mdio_in};
      if (fall_tick) begin
        sreg_d = {sreg_q[FRAME_LEN-2:0], 1'b0};
        idx_d  = idx_q + IW'(1);
        if (last_bit) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      idx_q  <= idx_d;
      act_q  <= act_d;
      wr_q   <= wr_d;
      cap_q  <= cap_d;
    end
  end

  assign active   = act_q;
  assign rdata    = cap_q;
  assign mdio_out = sreg_q[FRAME_LEN-1];
  assign mdio_oe  = act_q && (wr_q || (idx_q < IW'(TA_IDX)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic        csr_sel,
  input  logic [31:0] csr_wdata,
  output logic [31:0] ctl_rdata,
  output logic [31:0] dat_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic              rs_q1, rs_q2, rst_i_n;
  logic [PHY_W-1:0]  phy_q, phy_d;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              busy, done, start;
  logic              rise_tick, fall_tick;
  logic [DATA_W-1:0] rd_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i_n = rs_q2;

  always_comb begin
    start  = csr_wr && (csr_sel == SEL_CTRL) && !busy;
    phy_d  = phy_q;
    reg_d  = reg_q;
    wr_d   = wr_q;
    data_d = data_q;
    if (start) begin
      phy_d = csr_wdata[POS_PHY +: PHY_W];
      reg_d = csr_wdata[POS_REG +: REG_W];
      wr_d  = csr_wdata[POS_WR];
    end
    if (csr_wr && (csr_sel == SEL_DATA)) data_d = csr_wdata[DATA_W-1:0];
    if (done && !wr_q) data_d = rd_cap;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phy_q  <= '0;
      reg_q  <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      phy_q  <= phy_d;
      reg_q  <= reg_d;
      wr_q   <= wr_d;
      data_q <= data_d;
    end
  end

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (start),
    .wr        (csr_wdata[POS_WR]),
    .phy       (csr_wdata[POS_PHY +: PHY_W]),
    .regad     (csr_wdata[POS_REG +: REG_W]),
    .wdata     (data_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_in   (mdio_in),
    .active    (busy),
    .done      (done),
    .rdata     (rd_cap),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe)
  );

  always_comb begin
    ctl_rdata                      = '0;
    ctl_rdata[POS_PHY +: PHY_W]    = phy_q;
    ctl_rdata[POS_REG +: REG_W]    = reg_q;
    ctl_rdata[POS_WR]              = wr_q;
    ctl_rdata[POS_BUSY]            = busy;
    dat_rdata                      = {{(32-DATA_W){1'b0}}, data_q};
  end
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_wr,
  input logic        csr_sel,
  input logic [31:0] csr_wdata,
  input logic [31:0] ctl_rdata,
  input logic [31:0] dat_rdata,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        mdio_in
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[31:16] == 16'h0) && (ctl_rdata[5:2] == 4'h0) && (dat_rdata[31:16] == 16'h0));

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_sel && !ctl_rdata[0]) |=> ctl_rdata[0]);

  assert_idle_mdc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[0] |-> (!mdc && !mdio_oe));

  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_sel && ctl_rdata[0]) |=> $stable(ctl_rdata[15:1]));

  assert_mdio_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rdata[0]) && ctl_rdata[0] && !$stable(mdio_out)) |-> $fell(mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_wr    (csr_wr),
  .csr_sel   (csr_sel),
  .csr_wdata (csr_wdata),
  .ctl_rdata (ctl_rdata),
  .dat_rdata (dat_rdata),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .mdio_in   (mdio_in)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int HALF_DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic        csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] ctl_rdata, dat_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] cap_bits, cap_oe;
  int          rise_n;
  logic [15:0] phy_ans;

  always #2 clk = !clk;

  mdio_mgmt_ctrl #(.HALF_DIV(HALF_DIV), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY model: record on rising MDC, answer on falling MDC
  always @(posedge mdc) begin
    if (rise_n < 64) begin
      cap_bits[63 - rise_n] = mdio_out;
      cap_oe[63 - rise_n]   = mdio_oe;
    end
    rise_n = rise_n + 1;
  end

  always @(negedge mdc) begin
    if (rise_n >= 48 && rise_n <= 63) mdio_in = phy_ans[63 - rise_n];
    else if (rise_n == 47)            mdio_in = 1'b0;
    else                              mdio_in = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (ctl_rdata[0] && cycles < 2000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] frame(input logic w, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10, d};
  endfunction

  // {write flag, phy, reg, data reg value, phy answer}
  localparam logic [42:0] VECS [0:5] = '{
    {1'b1, 5'h01, 5'h00, 16'h1200, 16'h0000},
    {1'b0, 5'h01, 5'h01, 16'h0000, 16'h786D},
    {1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000},
    {1'b0, 5'h10, 5'h02, 16'h0000, 16'h0141},
    {1'b1, 5'h00, 5'h04, 16'h8001, 16'h0000},
    {1'b0, 5'h0A, 5'h15, 16'hAAAA, 16'hC35A}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int cyc;
    rise_n = 0;
    phy_ans = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R1 reset ctl", 64'(ctl_rdata), 64'h0);
    check("R1 reset data", 64'(dat_rdata), 64'h0);
    check("R3 idle mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);

    foreach (VECS[i]) begin
      logic w; logic [4:0] p, r; logic [15:0] d, a; logic [63:0] exp;
      {w, p, r, d, a} = VECS[i];
      phy_ans = a;
      csr_write(1'b1, {16'hDEAD, d});
      check("R1 data readback", 64'(dat_rdata), {48'h0, d});
      rise_n = 0;
      csr_write(1'b0, {16'h0, p, r, 4'h0, w, 1'b0});
      check("R2 busy after start", 64'(ctl_rdata), {48'h0, p, r, 4'h0, w, 1'b1});
      wait_idle(cyc);
      @(negedge clk);
      check("R3 busy clears", {63'h0, ctl_rdata[0]}, 64'h0);
      check("R8 rise count", 64'(rise_n), 64'd64);
      exp = frame(w, p, r, d);
      if (w) begin
        check("R4 write frame", cap_bits, exp);
        check("R4 write oe", cap_oe, {64{1'b1}});
        check("R4 data kept", 64'(dat_rdata), {48'h0, d});
      end else begin
        check("R5 read header", {18'h0, cap_bits[63:18]}, {18'h0, exp[63:18]});
        check("R5 read oe", cap_oe, {{46{1'b1}}, 18'h0});
        check("R6 read data", 64'(dat_rdata), {48'h0, a});
      end
    end

    // R1: reserved bits masked (all-ones write starts a write transaction)
    csr_write(1'b1, 32'h0000_5A5A);
    rise_n = 0;
    csr_write(1'b0, 32'hFFFF_FFFF);
    check("R1 reserved zero", 64'(ctl_rdata), 64'h0000_FFC3);
    // R7: control write while busy ignored
    repeat (20) @(negedge clk);
    csr_write(1'b0, 32'h0000_0840);
    check("R7 fields unchanged", 64'(ctl_rdata), 64'h0000_FFC3);
    wait_idle(cyc);
    @(negedge clk);
    check("R7 frame intact", cap_bits, frame(1'b1, 5'h1F, 5'h1F, 16'h5A5A));

    // R8: transaction length
    phy_ans = 16'h1234;
    rise_n = 0;
    csr_write(1'b0, 32'h0000_0880);
    wait_idle(cyc);
    check("R8 busy length", 64'(cyc), 64'(128 * HALF_DIV));
    check("R6 read after timing", 64'(dat_rdata), 64'h1234);
    check("R3 idle after", {62'h0, mdc, mdio_oe}, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule